// File: doc/BRIEF.md
# Double-Buffered DAC Command Controller

This block sits between a serial receiver and a digital-to-analog converter core. The receiver hands it complete 24-bit command words. The block keeps two registers. The staging register holds a code that has been written but not yet applied. The output register holds the code the converter is driving. The block also tracks whether the converter is asleep, and it times how long the output needs to settle after the converter wakes.

An active-low, asynchronous load strobe also moves the staging register into the output register. The strobe first passes through a synchronizer, and both its falling edge and its low level are judged on the system clock. How the strobe interacts with a word still in flight, with a word that has just completed, and with a pending sleep command is the core of the block. A resolution parameter (12, 14 or 16 bits) sets how many data bits form the code. A variant parameter sets whether reset leaves both registers at zero scale or at mid-scale.

Top module: `dac_cmd_ctrl`

## Requirements
- R1: The command is bits 23:20 of the word. The code is the top RES bits of bits 15:0, left-justified. Bits 19:16 and any trailing low bits are ignored.
- R2: Command 4'h0 loads the code into the staging register and leaves the output register unchanged.
- R3: Command 4'h1 copies the staging register into the output register and wakes the converter.
- R4: Command 4'h3 loads the code into both registers and wakes the converter.
- R5: Command 4'h4 puts the converter to sleep. Its data field is ignored, and neither register changes.
- R6: Command 4'hF and every other unlisted code change nothing.
- R7: After reset, the sleep flag is low and ready is high. Both registers hold zero, or 1 followed by RES-1 zeros when MID_RESET is 1.
- R8: A falling edge of the load strobe copies the staging register into the output register and wakes the converter. This happens only while a completed word is held and no transfer is in progress. The output changes on the third clock edge after the strobe falls.
- R9: A falling edge of the load strobe wakes the converter without changing the output in two cases: while a transfer is in progress, or when no word has completed since the last transfer started or since reset.
- R10: If the load strobe is low when a word completes, the command executes and the output register then takes the resulting staging value. A sleep command in that word is inhibited.
- R11: Ready is low while the converter sleeps. After a wake, ready stays low until WAKE_CYCLES+1 clock edges after the edge that cleared the sleep flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid_i | input | 1 | One-cycle pulse: a complete word is on word_i |
| word_i | input | 24 | Received command word |
| xfer_busy_i | input | 1 | A serial transfer is in progress and not yet complete |
| load_n_i | input | 1 | Asynchronous active-low load strobe |
| dac_code_o | output | RES | Output register, drives the converter |
| sleep_o | output | 1 | Converter is powered down |
| ready_o | output | 1 | Converter awake and output settled |

## Verification
The hardest situation to reach is the load strobe held low at the moment a word completes. In that case the level, not the edge, decides the result, and a sleep command must be suppressed. The bench drives the strobe low, waits for the synchronizer to pass the falling edge, and only then delivers a sleep word and a load-only word. It checks that the sleep flag stays low and that the output follows the freshly loaded value. A second hard case is a strobe edge after a transfer started and was then abandoned. The bench raises and drops the busy line without delivering a word before pulling the strobe low.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    typedef enum logic [3:0] {
        CMD_LOAD      = 4'h0,
        CMD_PUSH      = 4'h1,
        CMD_LOAD_PUSH = 4'h3,
        CMD_SLEEP     = 4'h4,
        CMD_IDLE      = 4'hF
    } cmd_e;

    typedef struct packed {
        logic load;
        logic push;
        logic sleep;
    } act_t;

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int RES = 16
) (
    input  logic [23:0]    word_i,
    output act_t           act_o,
    output logic [RES-1:0] code_o
);
    localparam int PAD = 16 - RES;

    logic unused_bits;

    always_comb begin
        act_o = '0;
        case (cmd_e'(word_i[23:20]))
            CMD_LOAD:      act_o.load = 1'b1;
            CMD_PUSH:      act_o.push = 1'b1;
            CMD_LOAD_PUSH: begin
                act_o.load = 1'b1;
                act_o.push = 1'b1;
            end
            CMD_SLEEP:     act_o.sleep = 1'b1;
            default:       act_o = '0;
        endcase
    end

    assign code_o = word_i[15:PAD];

    generate
        if (PAD > 0) begin : g_pad
            assign unused_bits = ^{word_i[19:16], word_i[PAD-1:0]};
        end else begin : g_nopad
            assign unused_bits = ^word_i[19:16];
        end
    endgenerate

endmodule

// File: rtl/dac_load_sync.sv
module dac_load_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic load_n_i,
    output logic low_o,
    output logic fall_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d    = q;
        d.s1 = load_n_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign low_o  = !q.s2;
    assign fall_o = q.s3 && !q.s2;

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o);   // R8

endmodule

// File: rtl/dac_wake_timer.sv
module dac_wake_timer #(
    parameter int WAKE_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_i,
    output logic ready_o
);
    localparam int CW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
    } tmr_t;

    tmr_t q, d;
    logic woke;

    assign woke = q.prev && !sleep_i;

    always_comb begin
        d      = q;
        d.prev = sleep_i;
        if (woke)             d.cnt = CW'(WAKE_CYCLES);
        else if (q.cnt != '0) d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ready_o = !sleep_i && !woke && (q.cnt == '0);

    AST_ASLEEP_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |-> !ready_o);   // R11
    AST_WAKE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.prev && !sleep_i) |=> (q.cnt == CW'(WAKE_CYCLES)));   // R11

endmodule

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
    import dac_cmd_pkg::*;
#(
    parameter int RES         = 16,
    parameter bit MID_RESET   = 1'b0,
    parameter int WAKE_CYCLES = 600
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           word_valid_i,
    input  logic [23:0]    word_i,
    input  logic           xfer_busy_i,
    input  logic           load_n_i,
    output logic [RES-1:0] dac_code_o,
    output logic           sleep_o,
    output logic           ready_o
);
    localparam logic [RES-1:0] RST_CODE =
        MID_RESET ? {1'b1, {(RES-1){1'b0}}} : '0;

    typedef struct packed {
        logic [RES-1:0] stage;
        logic [RES-1:0] dac;
        logic           sleep;
        logic           held;
    } ctl_t;

    ctl_t q, d;
    act_t act;
    logic [RES-1:0] code;
    logic ld_low, ld_fall;

    dac_cmd_decode #(.RES(RES)) u_dec (
        .word_i (word_i),
        .act_o  (act),
        .code_o (code)
    );

    dac_load_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (load_n_i),
        .low_o    (ld_low),
        .fall_o   (ld_fall)
    );

    dac_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (q.sleep),
        .ready_o (ready_o)
    );

    always_comb begin
        d = q;
        if (word_valid_i) begin
            d.held = 1'b1;
            if (act.load) d.stage = code;
            if (act.push) begin
                d.dac   = d.stage;
                d.sleep = 1'b0;
            end
            if (act.sleep && !ld_low) d.sleep = 1'b1;
            if (ld_low) begin
                d.dac   = d.stage;
                d.sleep = 1'b0;
            end
        end else begin
            if (xfer_busy_i) d.held = 1'b0;
            if (ld_fall) begin
                d.sleep = 1'b0;
                if (q.held && !xfer_busy_i) d.dac = q.stage;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.stage <= RST_CODE;
            q.dac   <= RST_CODE;
            q.sleep <= 1'b0;
            q.held  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign dac_code_o = q.dac;
    assign sleep_o    = q.sleep;

    AST_SLEEP_BY_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sleep) |-> $past(word_valid_i));   // R5
    AST_SLEEP_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid_i && ld_low) |=> !q.sleep);   // R10
    AST_DAC_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.dac) |-> ($past(word_valid_i) || $past(ld_fall)));   // R8
    AST_FALL_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_fall && !word_valid_i) |=> !q.sleep);   // R9

endmodule

// File: tb/dac_cmd_ctrl_test.sv
module dac_cmd_ctrl_test;
    localparam int W = 600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic word_valid = 1'b0;
    logic [23:0] word = '0;
    logic busy = 1'b0;
    logic load_n = 1'b1;
    logic [15:0] dac16;
    logic [11:0] dac12;
    logic sl16, sl12, rd16, rd12;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] e_stage, e_dac;
    logic [11:0] e_stage12, e_dac12;
    logic        e_sleep;

    always #10 clk = ~clk;

    dac_cmd_ctrl #(.RES(16), .MID_RESET(1'b0), .WAKE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid), .word_i(word),
        .xfer_busy_i(busy), .load_n_i(load_n),
        .dac_code_o(dac16), .sleep_o(sl16), .ready_o(rd16));

    dac_cmd_ctrl #(.RES(12), .MID_RESET(1'b1), .WAKE_CYCLES(W)) uut12 (
        .clk(clk), .rst_n(rst_n), .word_valid_i(word_valid), .word_i(word),
        .xfer_busy_i(busy), .load_n_i(load_n),
        .dac_code_o(dac12), .sleep_o(sl12), .ready_o(rd12));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] cmd, input logic [15:0] val);
        @(negedge clk);
        word = {cmd, 4'h9, val};
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
        word = '0;
    endtask

    task automatic model(input logic [3:0] cmd, input logic [15:0] val, input bit low);
        case (cmd)
            4'h0: begin e_stage = val; e_stage12 = val[15:4]; end
            4'h1: begin e_dac = e_stage; e_dac12 = e_stage12; e_sleep = 1'b0; end
            4'h3: begin
                e_stage = val; e_stage12 = val[15:4];
                e_dac = val; e_dac12 = val[15:4]; e_sleep = 1'b0;
            end
            4'h4: if (!low) e_sleep = 1'b1;
            default: ;
        endcase
        if (low) begin e_dac = e_stage; e_dac12 = e_stage12; e_sleep = 1'b0; end
    endtask

    task automatic all_out(input string tag);
        check({tag, " dac16"}, 32'(dac16), 32'(e_dac));
        check({tag, " dac12"}, 32'(dac12), 32'(e_dac12));
        check({tag, " sleep"}, 32'(sl16), 32'(e_sleep));
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        @(negedge clk);
        e_stage = 16'h0; e_dac = 16'h0; e_stage12 = 12'h800; e_dac12 = 12'h800; e_sleep = 1'b0;
        all_out("R7 reset");
        check("R7 ready16", 32'(rd16), 32'd1);
        check("R7 ready12", 32'(rd12), 32'd1);

        // R9: no word held since reset, edge wakes only
        load_n = 1'b0; wait_n(4);
        all_out("R9 no word held");
        load_n = 1'b1; wait_n(4);

        // R1..R6: sweep every command code; a push afterwards exposes the staging register
        for (int c = 0; c < 16; c++) begin
            logic [15:0] v;
            v = 16'hA5C3 ^ 16'(c * 16'h1357);
            send(4'h3, 16'h1234);
            model(4'h3, 16'h1234, 1'b0);
            send(4'(c), v);
            model(4'(c), v, 1'b0);
            all_out($sformatf("R1-cmd%0h (R2 R3 R4 R5 R6)", c));
            send(4'h1, 16'h0000);
            model(4'h1, 16'h0000, 1'b0);
            all_out($sformatf("R5 R6 staging after cmd%0h", c));
        end

        // R11: wake timing
        send(4'h4, 16'hFFFF); model(4'h4, 16'hFFFF, 1'b0);
        check("R11 asleep not ready", 32'(rd16), 32'd0);
        send(4'h1, 16'h0); model(4'h1, 16'h0, 1'b0);
        check("R11 ready low at wake", 32'(rd16), 32'd0);
        wait_n(W);
        check("R11 ready low at end of window", 32'(rd16), 32'd0);
        @(negedge clk);
        check("R11 ready high after window", 32'(rd16), 32'd1);

        // R9: edge during transfer wakes, output holds
        send(4'h4, 16'h0); model(4'h4, 16'h0, 1'b0);
        send(4'h0, 16'h4321); model(4'h0, 16'h4321, 1'b0);
        @(negedge clk); busy = 1'b1;
        load_n = 1'b0; wait_n(4);
        e_sleep = 1'b0;
        all_out("R9 busy edge");
        load_n = 1'b1; wait_n(2);
        busy = 1'b0; wait_n(2);
        // R9: abandoned transfer cleared the held word
        load_n = 1'b0; wait_n(4);
        all_out("R9 abandoned transfer");
        load_n = 1'b1; wait_n(4);

        // R8: edge with held word copies staging, third edge latency
        send(4'h0, 16'h7E81); model(4'h0, 16'h7E81, 1'b0);
        load_n = 1'b0;
        wait_n(2);
        all_out("R8 before latency");
        @(negedge clk);
        e_dac = e_stage; e_dac12 = e_stage12;
        all_out("R8 edge update");
        load_n = 1'b1; wait_n(4);

        // R10: strobe already low when word completes
        load_n = 1'b0; wait_n(4);
        send(4'h4, 16'hBEEF); model(4'h4, 16'hBEEF, 1'b1);
        all_out("R10 sleep inhibited");
        send(4'h0, 16'h0C3F); model(4'h0, 16'h0C3F, 1'b1);
        all_out("R10 load with strobe low");
        send(4'hF, 16'h1111); model(4'hF, 16'h1111, 1'b1);
        all_out("R10 idle with strobe low");
        load_n = 1'b1; wait_n(4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule